// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a synchronous memory. It holds three registers. The first is an address counter. The second is a mask register, which selects the low-order counter bits that take part in counting. The third is a mirror register, which keeps the last address loaded from outside. On each clock edge the control inputs choose one operation. That operation is clear, load, increment or hold on the counter, or reset or load on the mask. A readback request may also be made in the same cycle, on either the counter or the mask.

During increment, only the bits the mask leaves free change. When the free portion is already all ones and another increment arrives, the counter does not roll over to zero. It reloads the mirror value instead, so the same block of addresses is sent again. When an increment brings the free portion to all ones, an active-low flag asserts. The flag stays asserted until the next counter clear, counter load or master reset.

The current counter value drives the RAM decoder directly. A separate registered output returns the readback value one clock after the request. An asynchronous master reset puts every register into a known state.

Top module: `burst_addr_gen`

## Requirements
- R1: While `mrst_n` is low, `ram_addr` is 0, the mask is all ones, the mirror is 0, `rb_addr` is 0 and `cint_n` is 1.
- R2: A counter clear (`sel_mask`=0, `clr`=1) makes `ram_addr` 0 after that edge, with no extra cycle. It also sets `cint_n` to 1 and leaves the mirror unchanged. A clear wins over `load` and `inc`.
- R3: A counter load (`sel_mask`=0, `clr`=0, `load`=1) writes `addr_in` to both the counter and the mirror and sets `cint_n` to 1. A load wins over `inc`.
- R4: An increment (`sel_mask`=0, `clr`=0, `load`=0, `inc`=1) whose free portion is not all ones adds 1 to the bits where the mask is 1. The bits where the mask is 0 keep their value.
- R5: An increment whose free portion is already all ones loads the mirror value into the counter (retransmit).
- R6: `cint_n` goes to 0 on an increment that brings the free portion to all ones. It then stays 0 through holds, increments, retransmits and mask operations until a counter clear, counter load or master reset.
- R7: With `sel_mask`=0 and none of `clr`, `load` or `inc` asserted, the counter holds its value.
- R8: A mask reset (`sel_mask`=1, `clr`=1) sets every mask bit to 1. A mask reset wins over a mask load.
- R9: A mask load (`sel_mask`=1, `clr`=0, `load`=1) writes `addr_in` to the mask and leaves the counter and the mirror unchanged. A valid mask has the form 2^n-1 with n≥1.
- R10: When `rdbk`=1, `rb_addr` shows, after that edge, the value held before the edge: the counter when `sel_mask`=0, the mask when `sel_mask`=1. When `rdbk`=0, `rb_addr` holds its value.
- R11: When `sel_mask`=1, `inc` has no effect and the counter holds.
- R12: With an all-ones mask, the whole 18-bit counter counts up through 3FFFFh. The next increment after that reloads the mirror.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| sel_mask | input | 1 | 0 selects the counter, 1 selects the mask, for `clr`, `load` and `rdbk` |
| clr | input | 1 | Clears the counter, or resets the mask to all ones |
| load | input | 1 | Loads `addr_in` into the counter and mirror, or into the mask |
| inc | input | 1 | Increments the counter (acts only when `sel_mask`=0) |
| rdbk | input | 1 | Requests readback of the selected register |
| addr_in | input | 18 | External address or mask value |
| ram_addr | output | 18 | Current counter value, to the RAM decoder |
| rb_addr | output | 18 | Registered readback value |
| cint_n | output | 1 | Counter interrupt flag, active low |

## Verification
The bench uses small masks so that the counter often reaches the top of the free range. At that point a design that rolls over to zero, or that carries into the masked upper bits, gives an address outside the retransmitted block. Clear, load and increment are often asserted together. This exposes a wrong priority, which would load when it should clear, or count when it should load. The flag is followed through holds, retransmits and mask operations, so a flag that releases by itself or never asserts shows up at once. Mask readback is checked against the last loaded mask, which would reveal a mask write that leaks into the counter or mirror. A directed run with the full mask crosses 3FFFFh and checks that the counter returns to the mirror and not to zero.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          sel_mask,
  input  logic          clr,
  input  logic          load,
  input  logic          inc,
  input  logic          rdbk,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] ram_addr,
  output logic [AW-1:0] rb_addr,
  output logic          cint_n
);

  logic [AW-1:0] cnt_q, mask_q, mirr_q, rb_q;
  logic          int_q;

  wire cnt_side = ~sel_mask;
  wire do_clr   = cnt_side & clr;
  wire do_load  = cnt_side & ~clr & load;
  wire do_inc   = cnt_side & ~clr & ~load & inc;
  wire msk_rst  = sel_mask & clr;
  wire msk_load = sel_mask & ~clr & load;

  wire [AW-1:0] plus1  = cnt_q + 1'b1;
  wire [AW-1:0] bumped = (cnt_q & ~mask_q) | (plus1 & mask_q);
  wire          at_top = (cnt_q & mask_q) == mask_q;
  wire          to_top = (bumped & mask_q) == mask_q;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      cnt_q  <= '0;
      mirr_q <= '0;
    end else if (do_clr) begin
      cnt_q  <= '0;
    end else if (do_load) begin
      cnt_q  <= addr_in;
      mirr_q <= addr_in;
    end else if (do_inc) begin
      cnt_q  <= at_top ? mirr_q : bumped;
    end
  end

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n)       mask_q <= '1;
    else if (msk_rst)  mask_q <= '1;
    else if (msk_load) mask_q <= addr_in;
  end

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n)                      int_q <= 1'b0;
    else if (do_clr || do_load)       int_q <= 1'b0;
    else if (do_inc && !at_top && to_top) int_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n)   rb_q <= '0;
    else if (rdbk) rb_q <= sel_mask ? mask_q : cnt_q;
  end

  assign ram_addr = cnt_q;
  assign rb_addr  = rb_q;
  assign cint_n   = ~int_q;

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!mrst_n)
    (!sel_mask && clr) |=> (ram_addr == '0 && cint_n));

  a_r3_load_value: assert property (@(posedge clk) disable iff (!mrst_n)
    (!sel_mask && !clr && load) |=> (ram_addr == $past(addr_in) && mirr_q == $past(addr_in)));

  a_r4_upper_kept: assert property (@(posedge clk) disable iff (!mrst_n)
    (do_inc && !at_top) |=> ((ram_addr & ~mask_q) == $past(cnt_q & ~mask_q)));

  a_r5_retransmit: assert property (@(posedge clk) disable iff (!mrst_n)
    (do_inc && at_top) |=> (ram_addr == $past(mirr_q)));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!mrst_n)
    (!cint_n && !(!sel_mask && (clr || load))) |=> !cint_n);

  a_r7_hold: assert property (@(posedge clk) disable iff (!mrst_n)
    (!sel_mask && !clr && !load && !inc) |=> $stable(ram_addr));

  a_r8_mask_reset: assert property (@(posedge clk) disable iff (!mrst_n)
    (sel_mask && clr) |=> (mask_q == '1));

  a_r11_mask_side_hold: assert property (@(posedge clk) disable iff (!mrst_n)
    sel_mask |=> ($stable(ram_addr) && $stable(mirr_q)));

  a_r10_rb_hold: assert property (@(posedge clk) disable iff (!mrst_n)
    !rdbk |=> $stable(rb_addr));

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 18;
  localparam time PERIOD = 10ns;
  localparam logic [AW-1:0] ONES = '1;

  logic clk = 1'b0, mrst_n = 1'b0;
  logic sel_mask = 0, clr = 0, load = 0, inc = 0, rdbk = 0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] ram_addr, rb_addr;
  logic cint_n;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [AW-1:0] m_cnt, m_mask, m_mir, m_rb;
  logic          m_int;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_gen #(.AW(AW)) u_burst_addr_gen (
    .clk(clk), .mrst_n(mrst_n), .sel_mask(sel_mask), .clr(clr), .load(load),
    .inc(inc), .rdbk(rdbk), .addr_in(addr_in),
    .ram_addr(ram_addr), .rb_addr(rb_addr), .cint_n(cint_n));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] next_count(logic [AW-1:0] c, logic [AW-1:0] m, logic [AW-1:0] mir);
    if ((c & m) == m) return mir;
    return (c & ~m) | ((c + 1'b1) & m);
  endfunction

  function automatic string op_tag();
    if (sel_mask && clr)  return "R8 mask reset";
    if (sel_mask && load) return "R9 mask load";
    if (sel_mask)         return "R11 mask side";
    if (clr)              return "R2 counter clear";
    if (load)             return "R3 counter load";
    if (inc) return ((m_cnt & m_mask) == m_mask) ? "R5 retransmit" : "R4 increment";
    return "R7 hold";
  endfunction

  task automatic model_step();
    logic [AW-1:0] c0, k0;
    c0 = m_cnt; k0 = m_mask;
    if (rdbk) m_rb = sel_mask ? k0 : c0;
    if (sel_mask) begin
      if (clr) m_mask = ONES;
      else if (load) m_mask = addr_in;
    end else if (clr) begin
      m_cnt = '0; m_int = 0;
    end else if (load) begin
      m_cnt = addr_in; m_mir = addr_in; m_int = 0;
    end else if (inc) begin
      if ((c0 & k0) != k0 && ((next_count(c0, k0, m_mir) & k0) == k0)) m_int = 1;
      m_cnt = next_count(c0, k0, m_mir);
    end
  endtask

  task automatic step(bit s, bit c, bit l, bit i, bit r, logic [AW-1:0] a);
    string tag;
    sel_mask = s; clr = c; load = l; inc = i; rdbk = r; addr_in = a;
    tag = op_tag();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " ram_addr"}, 32'(ram_addr), 32'(m_cnt));
    chk({tag, " cint_n (R6)"}, 32'(cint_n), 32'(!m_int));
    chk({r ? "R10 readback" : "R10 rb hold", " rb_addr"}, 32'(rb_addr), 32'(m_rb));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_cnt = '0; m_mask = ONES; m_mir = '0; m_rb = '0; m_int = 0;
    #(PERIOD * 2);
    @(negedge clk);
    chk("R1 reset ram_addr", 32'(ram_addr), 0);
    chk("R1 reset rb_addr", 32'(rb_addr), 0);
    chk("R1 reset cint_n", 32'(cint_n), 1);
    mrst_n = 1'b1;
    step(1, 0, 0, 0, 1, '0);
    chk("R1 reset mask all ones", 32'(rb_addr), 32'(ONES));

    // R12: full mask crossing the top of the address range
    step(0, 0, 1, 0, 0, 18'h3FFFD);
    step(0, 0, 0, 1, 0, '0);
    step(0, 0, 0, 1, 0, '0);
    chk("R12 at 3FFFF", 32'(ram_addr), 32'h3FFFF);
    chk("R12 flag low at top", 32'(cint_n), 0);
    step(0, 0, 0, 1, 0, '0);
    chk("R12 wraps to mirror", 32'(ram_addr), 32'h3FFFD);

    // R2 priority: clear beats load and inc
    step(0, 1, 1, 1, 0, 18'h12345);
    chk("R2 clear priority", 32'(ram_addr), 0);
    // R8 priority and R9 mask load readback
    step(1, 0, 1, 0, 0, 18'h0000F);
    step(1, 1, 1, 0, 1, 18'h00003);
    step(1, 0, 0, 0, 1, '0);
    chk("R8 clear beats load", 32'(rb_addr), 32'(ONES));

    // R4/R5: small mask with upper bits set
    step(1, 0, 1, 0, 0, 18'h00003);
    step(0, 0, 1, 0, 0, 18'h2A5C1);
    for (int k = 0; k < 6; k++) step(0, 0, 0, 1, 0, '0);

    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [AW-1:0] a;
      r = $urandom_range(0, 99);
      a = 18'($urandom);
      if (r < 6) begin
        int w = (r < 4) ? $urandom_range(1, 4) : $urandom_range(1, AW);
        step(1, $urandom_range(0, 7) == 0, 1, 1'($urandom), 1'($urandom), (ONES >> (AW - w)));
      end else if (r < 12) step(0, 1, 1'($urandom), 1'($urandom), 1'($urandom), a);
      else if (r < 20) step(0, 0, 1, 1'($urandom), 1'($urandom), a);
      else if (r < 26) step(1, 0, 0, 1'($urandom), 1, a);
      else if (r < 34) step(0, 0, 0, 0, 1'($urandom), a);
      else             step(0, 0, 0, 1, 1'($urandom), a);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial void'($urandom(32'd7151));
endmodule